// File: doc/BRIEF.md
# Data Access Address Translator

This block holds the decision path for data loads and stores in a memory-management unit. For each request it checks operand alignment and picks the privilege mode that governs the access. It then forms a physical address in one of three ways: by passing a physical request straight through, by mapping through the kernel superpage window, or by matching a candidate page-table entry that an external TLB supplies. It also checks the per-mode read or write enables and the fault-on-read and fault-on-write bits.

Every fault is reported as a fault code plus a status word of combined flag bits. A machine-check and cacheability stage runs after translation. It marks accesses to the uncacheable half of the physical space, clears the upper address bits of those accesses, and rejects the register-space region. All outputs are registered, so the result appears one clock after the request inputs are applied. TLB storage, replacement and event counting are outside this block.

Top module: `dmx_data_xlate`

## Requirements
- R1: Alignment is checked before anything else. If `req_va & (req_size-1)` is nonzero, the fault is ALIGN (code 1). The status is 0 for a load and only bit 0 (write) for a store. `req_size` is a byte count of 1, 2, 4 or 8.
- R2: With `req_phys` set, the physical address equals the virtual address, and no virtual-address validity check is made.
- R3: A virtual address whose bits 63:47 are not all equal raises a page fault (code 2). The status sets bad-VA (bit 5) and access violation (bit 1), plus write (bit 0) for a store.
- R4: The superpage window is selected when VA bits 47:41 equal 0x7E, and it takes priority over the TLB. It is allowed only when `cur_mode` is kernel (0); the effective mode is not used here. Otherwise the fault is ACV (code 3) with status bit 1, plus bit 0 for a store. On success the physical address is VA bits 39:0, with bits 43:40 copied from VA bit 40.
- R5: An entry matches when it is valid, its tag equals VA bits 47:13, and it is global or its ASN equals `cur_asn`. If there is no match, the status sets miss (bit 4), plus bit 0 for a store. The fault is MISS_PTE (code 5) when `req_ptacc` is set and MISS_DATA (code 4) otherwise.
- R6: The effective mode is `cur_mode` when `pc_lsb` is 0. When `pc_lsb` is 1, it is `alt_mode` if `req_alt` is set and kernel otherwise. Mode codes are kernel 0, executive 1, supervisor 2 and user 3. Bit m of an enable mask grants mode m.
- R7: A store whose effective-mode bit is clear in the write mask gives code 2 with status bits 0 and 1, plus bit 3 if the entry's fault-on-write bit is set. A permitted store to a fault-on-write entry gives code 2 with status bits 0 and 3.
- R8: A load whose effective-mode bit is clear in the read mask gives code 3 with status bit 1, plus bit 2 if the entry's fault-on-read bit is set. A permitted load to a fault-on-read entry gives code 2 with status bit 2.
- R9: On a permitted hit, the physical address is the entry's page number above VA bits 12:0.
- R10: If a translated address has any bit set above bit 43, the fault is machine check (code 6) with status 0.
- R11: If bit 43 of a translated address is set and bits 42:41 are not 01, the access is reported uncacheable and physical bits 42:35 are forced to 0.
- R12: An address with bit 43 set and bits 42:41 equal to 01 is register space and gives the unimplemented fault (code 7) with status 0.
- R13: Outputs update one clock after the inputs. Reset drives every output to 0. Whenever the fault code is NONE (0), the status is 0. On any fault the address output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_va | input | 64 | Virtual address of the access |
| req_size | input | 4 | Access size in bytes (1, 2, 4, 8) |
| req_write | input | 1 | 1 for a store, 0 for a load |
| pc_lsb | input | 1 | Low bit of the program counter (privileged-code marker) |
| req_alt | input | 1 | Use the alternate mode when in privileged code |
| req_phys | input | 1 | Request carries a physical address |
| req_ptacc | input | 1 | Request is a page-table access |
| cur_mode | input | 2 | Current data-access mode |
| alt_mode | input | 2 | Alternate mode |
| cur_asn | input | 8 | Current address-space number |
| ent_valid | input | 1 | Candidate entry valid |
| ent_tag | input | 35 | Candidate entry virtual page tag |
| ent_asn | input | 8 | Candidate entry address-space number |
| ent_global | input | 1 | Candidate entry matches every ASN |
| ent_ppn | input | 31 | Candidate entry physical page number |
| ent_rd_en | input | 4 | Read enable per mode |
| ent_wr_en | input | 4 | Write enable per mode |
| ent_fonr | input | 1 | Entry fault-on-read bit |
| ent_fonw | input | 1 | Entry fault-on-write bit |
| xl_pa | output | 44 | Physical address |
| xl_fault | output | 3 | Fault code |
| xl_status | output | 6 | Status flags (bit0 write, 1 ACV, 2 FONR, 3 FONW, 4 miss, 5 bad VA) |
| xl_uncached | output | 1 | Access is uncacheable |

## Verification
Each decision stage is separate from the others, and a wrong priority between stages shows as the wrong fault code on the very next clock. Examples are a misaligned bad address, a superpage address with a stale TLB entry, and a physical request with an invalid-looking address. A mistake in the effective-mode selection appears only where the current mode and the effective mode disagree, so the directed cases grant one mode in the masks and deny the other. A mistake in flag assembly appears in the status word of that same result. This is checked bit by bit against the flag values the requirements list for each fault path.

// File: rtl/dmx_pkg.sv
package dmx_pkg;

  typedef enum logic [2:0] {
    F_NONE      = 3'd0,
    F_ALIGN     = 3'd1,
    F_PAGE      = 3'd2,
    F_ACV       = 3'd3,
    F_MISS_DATA = 3'd4,
    F_MISS_PTE  = 3'd5,
    F_MCHK      = 3'd6,
    F_UNIMP     = 3'd7
  } fault_e;

  localparam int ST_W     = 6;
  localparam int ST_WR    = 0;
  localparam int ST_ACV   = 1;
  localparam int ST_FONR  = 2;
  localparam int ST_FONW  = 3;
  localparam int ST_MISS  = 4;
  localparam int ST_BADVA = 5;

  localparam logic [1:0] MODE_KERNEL = 2'd0;

endpackage

// File: rtl/dmx_front.sv
module dmx_front #(
  parameter int VA_W     = 64,
  parameter int VA_IMPL  = 48,
  parameter int SZ_W     = 4,
  parameter int MODE_W   = 2,
  parameter int SP_TAG_W = 7,
  parameter logic [SP_TAG_W-1:0] SP_TAG = 7'h7E
) (
  input  logic [VA_W-1:0]   va,
  input  logic [SZ_W-1:0]   size,
  input  logic              pc_lsb,
  input  logic              use_alt,
  input  logic [MODE_W-1:0] cur_mode,
  input  logic [MODE_W-1:0] alt_mode,
  output logic              misalign,
  output logic              va_bad,
  output logic              in_superpage,
  output logic [MODE_W-1:0] eff_mode
);

  localparam int HI_W = VA_W - VA_IMPL + 1;

  function automatic logic low_bits_set(input logic [SZ_W-1:0] a,
                                        input logic [SZ_W-1:0] sz);
    return |(a & (sz - 1'b1));
  endfunction

  function automatic logic not_canonical(input logic [HI_W-1:0] hi);
    return !((&hi) || !(|hi));
  endfunction

  always_comb begin
    misalign     = low_bits_set(va[SZ_W-1:0], size);
    va_bad       = not_canonical(va[VA_W-1:VA_IMPL-1]);
    in_superpage = (va[VA_IMPL-1 -: SP_TAG_W] == SP_TAG);
    if (!pc_lsb)      eff_mode = cur_mode;
    else if (use_alt) eff_mode = alt_mode;
    else              eff_mode = '0;
  end

endmodule

// File: rtl/dmx_perm.sv
module dmx_perm #(
  parameter int VPN_W  = 35,
  parameter int PG_SH  = 13,
  parameter int ASN_W  = 8,
  parameter int PPN_W  = 31,
  parameter int MODE_W = 2
) (
  input  logic [VPN_W-1:0]          vpn,
  input  logic [PG_SH-1:0]          offset,
  input  logic [ASN_W-1:0]          asn,
  input  logic                      is_write,
  input  logic [MODE_W-1:0]         eff_mode,
  input  logic                      e_valid,
  input  logic [VPN_W-1:0]          e_tag,
  input  logic [ASN_W-1:0]          e_asn,
  input  logic                      e_global,
  input  logic [PPN_W-1:0]          e_ppn,
  input  logic [(1<<MODE_W)-1:0]    e_rd_en,
  input  logic [(1<<MODE_W)-1:0]    e_wr_en,
  output logic                      hit,
  output logic                      perm_ok,
  output logic [PPN_W+PG_SH-1:0]    pa_tlb
);

  function automatic logic entry_match(input logic v, input logic same_tag,
                                       input logic glob, input logic same_asn);
    return v && same_tag && (glob || same_asn);
  endfunction

  always_comb begin
    hit     = entry_match(e_valid, e_tag == vpn, e_global, e_asn == asn);
    perm_ok = is_write ? e_wr_en[eff_mode] : e_rd_en[eff_mode];
    pa_tlb  = {e_ppn, offset};
  end

endmodule

// File: rtl/dmx_post.sv
module dmx_post #(
  parameter int VA_W  = 64,
  parameter int PA_W  = 44,
  parameter int CLR_W = 8
) (
  input  logic [VA_W-1:0] pa_full,
  output logic            mchk,
  output logic            regspace,
  output logic            uncached,
  output logic [PA_W-1:0] pa_out
);

  localparam int UC_BIT = PA_W - 1;

  function automatic logic [PA_W-1:0] strip_hi(input logic [PA_W-1:0] p);
    logic [PA_W-1:0] r;
    r = p;
    r[UC_BIT-1 -: CLR_W] = '0;
    return r;
  endfunction

  logic uc_space;

  always_comb begin
    mchk     = |pa_full[VA_W-1:PA_W];
    uc_space = pa_full[UC_BIT];
    regspace = uc_space && (pa_full[UC_BIT-1 -: 2] == 2'b01);
    uncached = uc_space && !regspace;
    pa_out   = uncached ? strip_hi(pa_full[PA_W-1:0]) : pa_full[PA_W-1:0];
  end

endmodule

// File: rtl/dmx_data_xlate.sv
module dmx_data_xlate
  import dmx_pkg::*;
#(
  parameter int VA_W    = 64,
  parameter int VA_IMPL = 48,
  parameter int PA_W    = 44,
  parameter int PG_SH   = 13,
  parameter int ASN_W   = 8,
  parameter int SZ_W    = 4,
  parameter int MODE_W  = 2,
  parameter int CLR_W   = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [VA_W-1:0]            req_va,
  input  logic [SZ_W-1:0]            req_size,
  input  logic                       req_write,
  input  logic                       pc_lsb,
  input  logic                       req_alt,
  input  logic                       req_phys,
  input  logic                       req_ptacc,
  input  logic [MODE_W-1:0]          cur_mode,
  input  logic [MODE_W-1:0]          alt_mode,
  input  logic [ASN_W-1:0]           cur_asn,
  input  logic                       ent_valid,
  input  logic [VA_IMPL-PG_SH-1:0]   ent_tag,
  input  logic [ASN_W-1:0]           ent_asn,
  input  logic                       ent_global,
  input  logic [PA_W-PG_SH-1:0]      ent_ppn,
  input  logic [(1<<MODE_W)-1:0]     ent_rd_en,
  input  logic [(1<<MODE_W)-1:0]     ent_wr_en,
  input  logic                       ent_fonr,
  input  logic                       ent_fonw,
  output logic [PA_W-1:0]            xl_pa,
  output logic [2:0]                 xl_fault,
  output logic [ST_W-1:0]            xl_status,
  output logic                       xl_uncached
);

  localparam int VPN_W   = VA_IMPL - PG_SH;
  localparam int PPN_W   = PA_W - PG_SH;
  localparam int SP_SIGN = PA_W - 4;

  // events brought out for the checks
  logic              misalign, va_bad, in_superpage, sp_deny;
  logic [MODE_W-1:0] eff_mode;
  logic              hit, perm_ok;
  logic [PA_W-1:0]   pa_tlb;
  logic              translated;
  logic [VA_W-1:0]   pa_full;
  logic              post_mchk, post_reg, post_uc;
  logic [PA_W-1:0]   post_pa;

  fault_e            fault_n, fault_q;
  logic [ST_W-1:0]   status_n, status_q;
  logic [PA_W-1:0]   pa_n, pa_q;
  logic              uc_n, uc_q;

  dmx_front #(
    .VA_W(VA_W), .VA_IMPL(VA_IMPL), .SZ_W(SZ_W), .MODE_W(MODE_W)
  ) u_front (
    .va(req_va), .size(req_size), .pc_lsb(pc_lsb), .use_alt(req_alt),
    .cur_mode(cur_mode), .alt_mode(alt_mode),
    .misalign(misalign), .va_bad(va_bad), .in_superpage(in_superpage),
    .eff_mode(eff_mode)
  );

  dmx_perm #(
    .VPN_W(VPN_W), .PG_SH(PG_SH), .ASN_W(ASN_W), .PPN_W(PPN_W), .MODE_W(MODE_W)
  ) u_perm (
    .vpn(req_va[VA_IMPL-1:PG_SH]), .offset(req_va[PG_SH-1:0]), .asn(cur_asn),
    .is_write(req_write), .eff_mode(eff_mode),
    .e_valid(ent_valid), .e_tag(ent_tag), .e_asn(ent_asn), .e_global(ent_global),
    .e_ppn(ent_ppn), .e_rd_en(ent_rd_en), .e_wr_en(ent_wr_en),
    .hit(hit), .perm_ok(perm_ok), .pa_tlb(pa_tlb)
  );

  dmx_post #(
    .VA_W(VA_W), .PA_W(PA_W), .CLR_W(CLR_W)
  ) u_post (
    .pa_full(pa_full), .mchk(post_mchk), .regspace(post_reg),
    .uncached(post_uc), .pa_out(post_pa)
  );

  assign sp_deny = in_superpage && (cur_mode != MODE_KERNEL);

  always_comb begin
    fault_n    = F_NONE;
    status_n   = '0;
    translated = 1'b0;
    pa_full    = '0;
    if (misalign) begin
      fault_n         = F_ALIGN;
      status_n[ST_WR] = req_write;
    end else if (req_phys) begin
      translated = 1'b1;
      pa_full    = req_va;
    end else if (va_bad) begin
      fault_n            = F_PAGE;
      status_n[ST_WR]    = req_write;
      status_n[ST_BADVA] = 1'b1;
      status_n[ST_ACV]   = 1'b1;
    end else if (in_superpage) begin
      if (sp_deny) begin
        fault_n          = F_ACV;
        status_n[ST_WR]  = req_write;
        status_n[ST_ACV] = 1'b1;
      end else begin
        translated = 1'b1;
        pa_full    = {{(VA_W-PA_W){1'b0}}, {(PA_W-SP_SIGN){req_va[SP_SIGN]}},
                      req_va[SP_SIGN-1:0]};
      end
    end else if (!hit) begin
      fault_n           = req_ptacc ? F_MISS_PTE : F_MISS_DATA;
      status_n[ST_WR]   = req_write;
      status_n[ST_MISS] = 1'b1;
    end else if (req_write) begin
      status_n[ST_WR] = 1'b1;
      if (!perm_ok) begin
        fault_n           = F_PAGE;
        status_n[ST_ACV]  = 1'b1;
        status_n[ST_FONW] = ent_fonw;
      end else if (ent_fonw) begin
        fault_n           = F_PAGE;
        status_n[ST_FONW] = 1'b1;
      end else begin
        status_n   = '0;
        translated = 1'b1;
        pa_full    = {{(VA_W-PA_W){1'b0}}, pa_tlb};
      end
    end else begin
      if (!perm_ok) begin
        fault_n           = F_ACV;
        status_n[ST_ACV]  = 1'b1;
        status_n[ST_FONR] = ent_fonr;
      end else if (ent_fonr) begin
        fault_n           = F_PAGE;
        status_n[ST_FONR] = 1'b1;
      end else begin
        translated = 1'b1;
        pa_full    = {{(VA_W-PA_W){1'b0}}, pa_tlb};
      end
    end

    pa_n = '0;
    uc_n = 1'b0;
    if (translated) begin
      if (post_mchk)     fault_n = F_MCHK;
      else if (post_reg) fault_n = F_UNIMP;
      else begin
        pa_n = post_pa;
        uc_n = post_uc;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_q  <= F_NONE;
      status_q <= '0;
      pa_q     <= '0;
      uc_q     <= 1'b0;
    end else begin
      fault_q  <= fault_n;
      status_q <= status_n;
      pa_q     <= pa_n;
      uc_q     <= uc_n;
    end
  end

  assign xl_fault    = fault_q;
  assign xl_status   = status_q;
  assign xl_pa       = pa_q;
  assign xl_uncached = uc_q;

  a_r1_align_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(misalign)) |-> (xl_fault == F_ALIGN));

  a_r4_superpage_kernel_only: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n && sp_deny && !misalign && !req_phys && !va_bad)
      |-> (xl_fault == F_ACV && xl_status[ST_ACV]));

  a_r5_miss_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (xl_fault == F_MISS_DATA || xl_fault == F_MISS_PTE)
      |-> (xl_status[ST_MISS] && !xl_status[ST_ACV]));

  a_r10_machine_check: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n && translated && post_mchk) |-> (xl_fault == F_MCHK && xl_status == '0));

  a_r11_uncached_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    xl_uncached |-> (xl_pa[PA_W-1] && xl_pa[PA_W-2 -: CLR_W] == '0 && xl_fault == F_NONE));

  a_r13_clean_status: assert property (@(posedge clk) disable iff (!rst_n)
    (xl_fault == F_NONE) |-> (xl_status == '0));

  a_r13_pa_zero_on_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (xl_fault != F_NONE) |-> (xl_pa == '0 && !xl_uncached));

endmodule

// File: tb/test_dmx_data_xlate.sv
module test_dmx_data_xlate;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] req_va;
  logic [3:0]  req_size;
  logic        req_write, pc_lsb, req_alt, req_phys, req_ptacc;
  logic [1:0]  cur_mode, alt_mode;
  logic [7:0]  cur_asn, ent_asn;
  logic        ent_valid, ent_global, ent_fonr, ent_fonw;
  logic [34:0] ent_tag;
  logic [30:0] ent_ppn;
  logic [3:0]  ent_rd_en, ent_wr_en;
  logic [43:0] xl_pa;
  logic [2:0]  xl_fault;
  logic [5:0]  xl_status;
  logic        xl_uncached;

  int n_cmp = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  dmx_data_xlate i_dmx_data_xlate (
    .clk(clk), .rst_n(rst_n), .req_va(req_va), .req_size(req_size),
    .req_write(req_write), .pc_lsb(pc_lsb), .req_alt(req_alt),
    .req_phys(req_phys), .req_ptacc(req_ptacc), .cur_mode(cur_mode),
    .alt_mode(alt_mode), .cur_asn(cur_asn), .ent_valid(ent_valid),
    .ent_tag(ent_tag), .ent_asn(ent_asn), .ent_global(ent_global),
    .ent_ppn(ent_ppn), .ent_rd_en(ent_rd_en), .ent_wr_en(ent_wr_en),
    .ent_fonr(ent_fonr), .ent_fonw(ent_fonw), .xl_pa(xl_pa),
    .xl_fault(xl_fault), .xl_status(xl_status), .xl_uncached(xl_uncached)
  );

  task automatic defaults();
    req_va = 64'h0; req_size = 4'd1; req_write = 0; pc_lsb = 0; req_alt = 0;
    req_phys = 0; req_ptacc = 0; cur_mode = 2'd0; alt_mode = 2'd0; cur_asn = 8'd7;
    ent_valid = 1; ent_tag = 35'h12; ent_asn = 8'd7; ent_global = 0;
    ent_ppn = 31'h55; ent_rd_en = 4'hF; ent_wr_en = 4'hF; ent_fonr = 0; ent_fonw = 0;
  endtask

  task automatic expect_out(input string tag, input logic [43:0] pa,
                            input logic [2:0] f, input logic [5:0] st, input logic uc);
    n_cmp++;
    if (xl_pa !== pa || xl_fault !== f || xl_status !== st || xl_uncached !== uc) begin
      n_bad++;
      $display("FAIL %s: got pa=%h fault=%0d status=%b uc=%b, expected pa=%h fault=%0d status=%b uc=%b",
               tag, xl_pa, xl_fault, xl_status, xl_uncached, pa, f, st, uc);
    end
  endtask

  // apply inputs at falling edge, sample just after the next rising edge
  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    #1;
    expect_out("R13 reset", 44'h0, 3'd0, 6'b0, 1'b0);
  endtask

  task automatic t_align();
    @(negedge clk); defaults(); req_va = 64'h1003; req_size = 4'd4; req_write = 1;
    step(); expect_out("R1 store misaligned", 44'h0, 3'd1, 6'b000001, 0);
    @(negedge clk); req_write = 0; req_size = 4'd2; req_va = 64'h0001_0000_0000_0001;
    step(); expect_out("R1 misaligned beats bad VA", 44'h0, 3'd1, 6'b0, 0);
  endtask

  task automatic t_phys();
    @(negedge clk); defaults(); req_phys = 1; req_va = 64'h0000_0123_4567_8ABC;
    step(); expect_out("R2 physical passthrough", 44'h123_4567_8ABC, 3'd0, 6'b0, 0);
    @(negedge clk); req_va = 64'h0001_0000_0000_0000;
    step(); expect_out("R2 no VA check, R10 high bit", 44'h0, 3'd6, 6'b0, 0);
    @(negedge clk); req_va = 64'h0000_1000_0000_0000;
    step(); expect_out("R10 machine check bit44", 44'h0, 3'd6, 6'b0, 0);
  endtask

  task automatic t_badva();
    @(negedge clk); defaults(); req_va = 64'h0001_0000_0000_0000;
    step(); expect_out("R3 bad VA load", 44'h0, 3'd2, 6'b100010, 0);
    @(negedge clk); req_write = 1;
    step(); expect_out("R3 bad VA store", 44'h0, 3'd2, 6'b100011, 0);
  endtask

  task automatic t_superpage();
    @(negedge clk); defaults(); ent_valid = 0; req_size = 4'd8;
    req_va = 64'hFFFF_FC00_0012_3450;
    step(); expect_out("R4 superpage kernel", 44'h000_0012_3450, 3'd0, 6'b0, 0);
    @(negedge clk); req_va = 64'hFFFF_FD00_0000_1000;
    step(); expect_out("R4 R11 superpage bit40 sign", 44'h800_0000_1000, 3'd0, 6'b0, 1);
    @(negedge clk); cur_mode = 2'd3; req_write = 1;
    step(); expect_out("R4 superpage user store", 44'h0, 3'd3, 6'b000011, 0);
    @(negedge clk); pc_lsb = 1; req_write = 0;
    step(); expect_out("R4 uses current not effective mode", 44'h0, 3'd3, 6'b000010, 0);
  endtask

  task automatic t_miss();
    @(negedge clk); defaults(); req_va = 64'h24ABC; req_size = 4'd4; ent_valid = 0;
    step(); expect_out("R5 invalid entry miss", 44'h0, 3'd4, 6'b010000, 0);
    @(negedge clk); req_ptacc = 1; req_write = 1;
    step(); expect_out("R5 page-table store miss", 44'h0, 3'd5, 6'b010001, 0);
    @(negedge clk); defaults(); req_va = 64'h24ABC; ent_tag = 35'h13;
    step(); expect_out("R5 tag mismatch", 44'h0, 3'd4, 6'b010000, 0);
    @(negedge clk); ent_tag = 35'h12; ent_asn = 8'd5;
    step(); expect_out("R5 asn mismatch", 44'h0, 3'd4, 6'b010000, 0);
    @(negedge clk); ent_global = 1;
    step(); expect_out("R5 R9 global hit", 44'h00_000A_AABC, 3'd0, 6'b0, 0);
  endtask

  task automatic t_load_perm();
    @(negedge clk); defaults(); req_va = 64'h24ABC; cur_mode = 2'd3; ent_rd_en = 4'b0001;
    step(); expect_out("R8 load denied", 44'h0, 3'd3, 6'b000010, 0);
    @(negedge clk); ent_fonr = 1;
    step(); expect_out("R8 load denied with fonr", 44'h0, 3'd3, 6'b000110, 0);
    @(negedge clk); ent_rd_en = 4'b1000;
    step(); expect_out("R8 permitted load fonr", 44'h0, 3'd2, 6'b000100, 0);
    @(negedge clk); ent_fonw = 1; ent_fonr = 0;
    step(); expect_out("R8 load ignores fonw", 44'h00_000A_AABC, 3'd0, 6'b0, 0);
  endtask

  task automatic t_store_perm();
    @(negedge clk); defaults(); req_va = 64'h24ABC; req_write = 1; cur_mode = 2'd2;
    ent_wr_en = 4'b1011;
    step(); expect_out("R7 store denied", 44'h0, 3'd2, 6'b000011, 0);
    @(negedge clk); ent_fonw = 1;
    step(); expect_out("R7 store denied with fonw", 44'h0, 3'd2, 6'b001011, 0);
    @(negedge clk); ent_wr_en = 4'b0100;
    step(); expect_out("R7 permitted store fonw", 44'h0, 3'd2, 6'b001001, 0);
    @(negedge clk); ent_fonw = 0; ent_fonr = 1;
    step(); expect_out("R7 R9 store hit ignores fonr", 44'h00_000A_AABC, 3'd0, 6'b0, 0);
  endtask

  task automatic t_mode();
    @(negedge clk); defaults(); req_va = 64'h24ABC; cur_mode = 2'd3; ent_rd_en = 4'b0001;
    pc_lsb = 1;
    step(); expect_out("R6 privileged code uses kernel", 44'h00_000A_AABC, 3'd0, 6'b0, 0);
    @(negedge clk); req_alt = 1; alt_mode = 2'd2;
    step(); expect_out("R6 alternate mode denied", 44'h0, 3'd3, 6'b000010, 0);
    @(negedge clk); ent_rd_en = 4'b0100;
    step(); expect_out("R6 alternate mode granted", 44'h00_000A_AABC, 3'd0, 6'b0, 0);
    @(negedge clk); pc_lsb = 0;
    step(); expect_out("R6 alt flag ignored outside privileged code", 44'h0, 3'd3, 6'b000010, 0);
  endtask

  task automatic t_uncached();
    @(negedge clk); defaults(); req_phys = 1; req_va = 64'h0000_08F0_0000_0040;
    step(); expect_out("R11 uncached clears 42:35", 44'h800_0000_0040, 3'd0, 6'b0, 1);
    @(negedge clk); req_va = 64'h0000_0A00_0000_0040;
    step(); expect_out("R12 register space", 44'h0, 3'd7, 6'b0, 0);
    @(negedge clk); req_va = 64'h0000_0200_0000_0040;
    step(); expect_out("R12 bit41 without bit43 cached", 44'h200_0000_0040, 3'd0, 6'b0, 0);
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog: got no finish, expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    defaults();
    t_reset();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    t_align();
    t_phys();
    t_badva();
    t_superpage();
    t_miss();
    t_load_perm();
    t_store_perm();
    t_mode();
    t_uncached();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule